// File: doc/BRIEF.md
# Pending Frame-End Event Tracker

This block keeps count of frame-completion events that a chained-block DMA channel has reported and that the host has not yet acknowledged. The first unserviced frame raises an end-of-message flag. Each further frame that completes while the flag is still up adds one to a 4-bit backlog count. The host works through the backlog by writing 1 to the flag. Each such write removes one pending event, and the flag drops only after the last one has been consumed.

If the backlog count is at its maximum and another frame completes, the block tells the channel to stop at that frame boundary. It then wraps the count to zero, keeps the flag raised and sets a sticky overflow flag, which can raise an interrupt. A clear command returns the tracker to its empty condition. Counting runs only when the counter-enable mode input is set and the channel is in chained-block mode. Otherwise the flag follows frame and acknowledge events directly, and the count does not move.

The control is a three-state machine. ST_IDLE means the flag is low. ST_ARMED means the flag is high and nothing extra is owed. ST_BACKLOG means the flag is high and the count is nonzero. The named transitions are:
- FRAME_RAISE: ST_IDLE to ST_ARMED.
- FRAME_QUEUE: ST_ARMED to ST_BACKLOG, or ST_BACKLOG to itself.
- FRAME_WRAP: ST_BACKLOG to ST_ARMED on overflow.
- ACK_CONSUME: ST_BACKLOG to ST_BACKLOG or ST_ARMED.
- ACK_RELEASE: ST_ARMED or ST_BACKLOG to ST_IDLE.
- CLEAR_ALL: any state to ST_IDLE.

Top module: `frame_pend_tracker`

## Requirements
- R1: After reset, every output is 0. `cnt_reg[7:4]` always reads 0, and `cnt_reg[3:0]` shows the count in chained mode.
- R2: With `cnt_en`=0 the count holds its value. The flag is then set by a frame and cleared by an acknowledge with no regard to the count.
- R3: While counting is active and the count is nonzero, the flag stays 1 in the next cycle unless a clear is issued.
- R4: When counting is active, the flag is 1 and the count is nonzero, an acknowledge decrements the count by one.
- R5: A frame at count 15, with the flag 1 and no acknowledge in the same cycle, pulses `stop_req` for one cycle. The count becomes 0 and the flag stays 1.
- R6: That overflow sets `ovf_flag`, which is sticky. `ovf_irq` is 1 exactly when `ovf_flag` and `ovf_ie` are both 1.
- R7: `clr_cmd` clears the flag, the count and `ovf_flag` in the next cycle.
- R8: With `chained_mode`=0, `cnt_reg` reads 0 and frames do not change the count.
- R9: When counting is active and the flag is 0, a frame sets the flag and leaves the count at 0. When the flag is already 1, a frame increments the count.
- R10: An acknowledge at count 0 with the flag 1 clears the flag. An acknowledge while the flag is 0 has no effect.
- R11: When counting is active, a frame and an acknowledge in the same cycle leave the flag and the count unchanged, and no overflow occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_done | input | 1 | Frame-complete pulse from the channel |
| ack_wr | input | 1 | Host write of 1 to the end-of-message flag |
| clr_cmd | input | 1 | Clear command strobe |
| cnt_en | input | 1 | Counter-enable mode bit |
| chained_mode | input | 1 | 1 = chained-block mode, 0 = single-block mode |
| ovf_ie | input | 1 | Overflow interrupt enable |
| eom_flag | output | 1 | End-of-message status flag |
| ovf_flag | output | 1 | Sticky counter-overflow status |
| ovf_irq | output | 1 | Overflow interrupt request |
| stop_req | output | 1 | One-cycle request to halt the channel |
| cnt_reg | output | 8 | Readable counter register |

## Verification
If the state machine and the counter fall out of step, the port view gives it away within one acknowledge. The flag either drops while `cnt_reg` is still nonzero, or it stays up after the count has reached 0. A wrong count shows on `cnt_reg` in the cycle after the event that caused it. A missed or spurious wrap shows in the same cycle as a missing or extra `stop_req` pulse together with a change on `ovf_flag`. The stimulus walks the backlog up to 15 and through the wrap, so an off-by-one at the full boundary shows up in the cycle of the sixteenth queued frame.

// File: rtl/fpt_pkg.sv
package fpt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ARMED   = 2'd1,
        ST_BACKLOG = 2'd2
    } fpt_state_e;

    typedef enum logic [2:0] {
        EV_NONE  = 3'd0,
        EV_FRAME = 3'd1,
        EV_ACK   = 3'd2,
        EV_BOTH  = 3'd3,
        EV_CLEAR = 3'd4
    } fpt_event_e;

    typedef enum logic [2:0] {
        CC_HOLD = 3'd0,
        CC_INC  = 3'd1,
        CC_DEC  = 3'd2,
        CC_WRAP = 3'd3,
        CC_CLR  = 3'd4
    } fpt_cnt_cmd_e;

endpackage

// File: rtl/fpt_event_decode.sv
module fpt_event_decode
    import fpt_pkg::*;
(
    input  logic       frm_done,
    input  logic       ack_wr,
    input  logic       clr_cmd,
    output fpt_event_e ev
);
    always_comb begin
        if (clr_cmd)
            ev = EV_CLEAR;
        else if (frm_done && ack_wr)
            ev = EV_BOTH;
        else if (frm_done)
            ev = EV_FRAME;
        else if (ack_wr)
            ev = EV_ACK;
        else
            ev = EV_NONE;
    end
endmodule

// File: rtl/fpt_counter.sv
module fpt_counter
    import fpt_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  fpt_cnt_cmd_e     cmd,
    output logic [CNT_W-1:0] count,
    output logic             is_zero,
    output logic             is_one,
    output logic             is_full
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            unique case (cmd)
                CC_INC:  count <= count + CNT_ONE;
                CC_DEC:  count <= count - CNT_ONE;
                CC_WRAP: count <= '0;
                CC_CLR:  count <= '0;
                default: count <= count;
            endcase
        end
    end

    assign is_zero = (count == '0);
    assign is_one  = (count == CNT_ONE);
    assign is_full = (count == CNT_MAX);
endmodule

// File: rtl/fpt_ctrl.sv
module fpt_ctrl
    import fpt_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  fpt_event_e   ev,
    input  logic         active,
    input  logic         cnt_zero,
    input  logic         cnt_one,
    input  logic         cnt_full,
    output fpt_state_e   state,
    output fpt_cnt_cmd_e cnt_cmd,
    output logic         ovf_flag,
    output logic         stop_req
);
    fpt_state_e state_nx;
    logic       ovf_set;
    logic       ovf_clr;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    // next state and outputs
    always_comb begin
        state_nx = state;
        cnt_cmd  = CC_HOLD;
        ovf_set  = 1'b0;
        ovf_clr  = 1'b0;
        if (ev == EV_CLEAR) begin
            // CLEAR_ALL
            state_nx = ST_IDLE;
            cnt_cmd  = CC_CLR;
            ovf_clr  = 1'b1;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (ev == EV_FRAME || (ev == EV_BOTH && !active))
                        state_nx = ST_ARMED;                 // FRAME_RAISE
                end
                ST_ARMED, ST_BACKLOG: begin
                    if (ev == EV_FRAME && active) begin
                        if (cnt_full) begin                  // FRAME_WRAP
                            cnt_cmd  = CC_WRAP;
                            ovf_set  = 1'b1;
                            state_nx = ST_ARMED;
                        end else begin                       // FRAME_QUEUE
                            cnt_cmd  = CC_INC;
                            state_nx = ST_BACKLOG;
                        end
                    end else if (ev == EV_ACK) begin
                        if (!active || cnt_zero) begin
                            state_nx = ST_IDLE;              // ACK_RELEASE
                        end else begin                       // ACK_CONSUME
                            cnt_cmd  = CC_DEC;
                            state_nx = cnt_one ? ST_ARMED : ST_BACKLOG;
                        end
                    end
                end
                default: state_nx = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_flag <= 1'b0;
            stop_req <= 1'b0;
        end else begin
            stop_req <= ovf_set;
            if (ovf_clr)
                ovf_flag <= 1'b0;
            else if (ovf_set)
                ovf_flag <= 1'b1;
        end
    end
endmodule

// File: rtl/frame_pend_tracker.sv
module frame_pend_tracker
    import fpt_pkg::*;
#(
    parameter int CNT_W = 4,
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frm_done,
    input  logic             ack_wr,
    input  logic             clr_cmd,
    input  logic             cnt_en,
    input  logic             chained_mode,
    input  logic             ovf_ie,
    output logic             eom_flag,
    output logic             ovf_flag,
    output logic             ovf_irq,
    output logic             stop_req,
    output logic [REG_W-1:0] cnt_reg
);
    localparam int PAD_W = REG_W - CNT_W;

    fpt_event_e       ev;
    fpt_cnt_cmd_e     cnt_cmd;
    fpt_state_e       state;
    logic [CNT_W-1:0] count;
    logic             cnt_zero;
    logic             cnt_one;
    logic             cnt_full;
    logic             active;

    assign active = cnt_en & chained_mode;

    fpt_event_decode u_dec (
        .frm_done (frm_done),
        .ack_wr   (ack_wr),
        .clr_cmd  (clr_cmd),
        .ev       (ev)
    );

    fpt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd     (cnt_cmd),
        .count   (count),
        .is_zero (cnt_zero),
        .is_one  (cnt_one),
        .is_full (cnt_full)
    );

    fpt_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev       (ev),
        .active   (active),
        .cnt_zero (cnt_zero),
        .cnt_one  (cnt_one),
        .cnt_full (cnt_full),
        .state    (state),
        .cnt_cmd  (cnt_cmd),
        .ovf_flag (ovf_flag),
        .stop_req (stop_req)
    );

    assign eom_flag = (state != ST_IDLE);
    assign ovf_irq  = ovf_flag & ovf_ie;
    assign cnt_reg  = chained_mode ? {{PAD_W{1'b0}}, count} : '0;
endmodule

// File: rtl/frame_pend_tracker_chk.sv
module frame_pend_tracker_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       frm_done,
    input logic       ack_wr,
    input logic       clr_cmd,
    input logic       cnt_en,
    input logic       chained_mode,
    input logic       eom_flag,
    input logic       ovf_flag,
    input logic       stop_req,
    input logic [7:0] cnt_reg
);
    logic act;
    assign act = cnt_en & chained_mode;

    a_r1_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_reg[7:4] == 4'd0);

    a_r2_hold_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en && chained_mode && !clr_cmd) |=> (!chained_mode || cnt_reg == $past(cnt_reg)));

    a_r3_sticky_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (act && eom_flag && cnt_reg[3:0] != 4'd0 && !clr_cmd) |=> eom_flag);

    a_r4_ack_decrements: assert property (@(posedge clk) disable iff (!rst_n)
        (act && eom_flag && cnt_reg[3:0] != 4'd0 && ack_wr && !frm_done && !clr_cmd)
        |=> (cnt_reg[3:0] == $past(cnt_reg[3:0]) - 4'd1));

    a_r5_wrap_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (act && eom_flag && cnt_reg[3:0] == 4'hF && frm_done && !ack_wr && !clr_cmd)
        |=> (stop_req && ovf_flag && eom_flag && cnt_reg[3:0] == 4'd0));

    a_r5_stop_single: assert property (@(posedge clk) disable iff (!rst_n)
        stop_req |=> !stop_req);

    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr_cmd |=> (!eom_flag && !ovf_flag && cnt_reg == 8'd0));

    a_r11_cancel: assert property (@(posedge clk) disable iff (!rst_n)
        (act && frm_done && ack_wr && !clr_cmd)
        |=> (!stop_req && $stable(eom_flag) && (!chained_mode || cnt_reg == $past(cnt_reg))));
endmodule

bind frame_pend_tracker frame_pend_tracker_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .frm_done     (frm_done),
    .ack_wr       (ack_wr),
    .clr_cmd      (clr_cmd),
    .cnt_en       (cnt_en),
    .chained_mode (chained_mode),
    .eom_flag     (eom_flag),
    .ovf_flag     (ovf_flag),
    .stop_req     (stop_req),
    .cnt_reg      (cnt_reg)
);

// File: tb/test_frame_pend_tracker.sv
module test_frame_pend_tracker;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frm_done = 1'b0, ack_wr = 1'b0, clr_cmd = 1'b0;
    logic       cnt_en = 1'b1, chained_mode = 1'b1, ovf_ie = 1'b1;
    logic       eom_flag, ovf_flag, ovf_irq, stop_req;
    logic [7:0] cnt_reg;
    int         n_run = 0, n_fail = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    frame_pend_tracker i_frame_pend_tracker (
        .clk(clk), .rst_n(rst_n), .frm_done(frm_done), .ack_wr(ack_wr),
        .clr_cmd(clr_cmd), .cnt_en(cnt_en), .chained_mode(chained_mode),
        .ovf_ie(ovf_ie), .eom_flag(eom_flag), .ovf_flag(ovf_flag),
        .ovf_irq(ovf_irq), .stop_req(stop_req), .cnt_reg(cnt_reg)
    );

    // inputs: frm ack clr en chained ie | expected: eom ovf irq stop | cnt
    localparam int NV = 18;
    localparam logic [13:0] VEC [NV] = '{
        {6'b100111, 4'b1000, 4'h0},  // R9 raise
        {6'b100111, 4'b1000, 4'h1},  // R9 queue
        {6'b100111, 4'b1000, 4'h2},  // R9 queue
        {6'b010111, 4'b1000, 4'h1},  // R4
        {6'b110111, 4'b1000, 4'h1},  // R11
        {6'b000111, 4'b1000, 4'h1},  // R3
        {6'b010111, 4'b1000, 4'h0},  // R4
        {6'b010111, 4'b0000, 4'h0},  // R10 release
        {6'b010111, 4'b0000, 4'h0},  // R10 ignored
        {6'b100011, 4'b1000, 4'h0},  // R2
        {6'b100011, 4'b1000, 4'h0},  // R2
        {6'b010011, 4'b0000, 4'h0},  // R2
        {6'b100111, 4'b1000, 4'h0},  // R9
        {6'b100111, 4'b1000, 4'h1},  // R9
        {6'b001111, 4'b0000, 4'h0},  // R7
        {6'b100101, 4'b1000, 4'h0},  // R8
        {6'b100101, 4'b1000, 4'h0},  // R8
        {6'b010101, 4'b0000, 4'h0}   // R8
    };

    function automatic string vec_tag(int i);
        case (i)
            0, 1, 2, 12, 13: return "R9";
            3, 6:            return "R4";
            4:               return "R11";
            5:               return "R3";
            7, 8:            return "R10";
            9, 10, 11:       return "R2";
            14:              return "R7";
            default:         return "R8";
        endcase
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic chk_all(string tag, logic e, logic o, logic q, logic s, logic [7:0] c);
        chk(tag, "eom_flag", int'(eom_flag), int'(e));
        chk(tag, "ovf_flag", int'(ovf_flag), int'(o));
        chk(tag, "ovf_irq",  int'(ovf_irq),  int'(q));
        chk(tag, "stop_req", int'(stop_req), int'(s));
        chk(tag, "cnt_reg",  int'(cnt_reg),  int'(c));
    endtask

    // drive at negedge, clock once, return at next negedge for sampling
    task automatic step(logic f, logic a, logic c, logic en, logic ch, logic ie);
        frm_done = f; ack_wr = a; clr_cmd = c;
        cnt_en = en; chained_mode = ch; ovf_ie = ie;
        @(negedge clk);
    endtask

    initial begin
        repeat (4000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk); @(negedge clk);
        chk_all("R1", 1'b0, 1'b0, 1'b0, 1'b0, 8'd0);   // reset state
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][13], VEC[i][12], VEC[i][11], VEC[i][10], VEC[i][9], VEC[i][8]);
            chk_all(vec_tag(i), VEC[i][7], VEC[i][6], VEC[i][5], VEC[i][4], {4'd0, VEC[i][3:0]});
        end

        // R5/R6: fill the backlog to 15, then wrap
        for (int k = 0; k < 16; k++) step(1, 0, 0, 1, 1, 1);
        chk_all("R5", 1'b1, 1'b0, 1'b0, 1'b0, 8'd15);
        step(1, 0, 0, 1, 1, 1);
        chk_all("R5", 1'b1, 1'b1, 1'b1, 1'b1, 8'd0);
        step(0, 0, 0, 1, 1, 1);
        chk_all("R6", 1'b1, 1'b1, 1'b1, 1'b0, 8'd0);    // sticky, stop one cycle
        step(0, 0, 0, 1, 1, 0);
        chk_all("R6", 1'b1, 1'b1, 1'b0, 1'b0, 8'd0);    // irq gated by enable
        step(1, 0, 0, 1, 1, 1);
        chk_all("R6", 1'b1, 1'b1, 1'b1, 1'b0, 8'd1);
        step(0, 0, 1, 1, 1, 1);
        chk_all("R7", 1'b0, 1'b0, 1'b0, 1'b0, 8'd0);

        // R11 at the full boundary: no wrap
        for (int k = 0; k < 16; k++) step(1, 0, 0, 1, 1, 1);
        step(1, 1, 0, 1, 1, 1);
        chk_all("R11", 1'b1, 1'b0, 1'b0, 1'b0, 8'd15);
        step(0, 1, 0, 1, 1, 1);
        chk_all("R4", 1'b1, 1'b0, 1'b0, 1'b0, 8'd14);

        // R1: reset mid-run
        rst_n = 1'b0;
        step(0, 0, 0, 1, 1, 1);
        chk_all("R1", 1'b0, 1'b0, 1'b0, 1'b0, 8'd0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule